// File: doc/BRIEF.md
# Dual Data Pointer Address Unit

This unit sits beside the core of an 8-bit controller. It holds two 16-bit data pointers and, for every external-data move or program-memory table read, forms the memory address. It also says whether the accumulator or the B register is the data register for that transfer. The decoder gives it the instruction class, a pointer-select bit and an "alternate pointer" flag, and the unit answers in the same cycle.

Two mode bits change the plain dual-pointer behaviour. Redirect sends transfers made through pointer 1 to B instead of the accumulator. Index-disable turns the accumulator-indexed table read into a plain read at the pointer address. Pointers are loaded one byte at a time and can be stepped by one. Both pointers can be read back.

Top module: `dptr_addr_unit`

## Requirements
- R1: After reset both pointers read back as zero and both mode bits are zero. So the first code read addresses the accumulator value and the data register is the accumulator (dataIsB=0).
- R2: When ptrWe is high on a clock edge, ptrWrData is loaded into one byte. ptrWrIdx picks the pointer (0 or 1). ptrWrHigh picks the byte: 1 means bits 15:8, 0 means bits 7:0. The other byte and the other pointer stay unchanged.
- R3: The effective pointer is ptrSelect XOR altPtr. With ptrSelect=1 the normal form uses pointer 1 and the alternate form uses pointer 0.
- R4: For an external read or write, memAddr equals the effective pointer value. Neither mode bit changes this address.
- R5: When mode bit 0 (redirect) is 1 and the effective pointer is pointer 1, an external read or write drives dataIsB=1.
- R6: A transfer through pointer 0 always drives dataIsB=0, whatever the mode bits are.
- R7: With redirect set, a code read through pointer 1 drives dataIsB=1. Its address is still indexed by the accumulator, never by B.
- R8: With mode bit 1 (index-disable) at 1, a code read addresses the effective pointer alone. With it at 0, the address is the pointer plus the zero-extended accumulator, modulo 2^16.
- R9: When incEn is high on a clock edge, the effective pointer steps by one and wraps from 0xFFFF to 0x0000. The other pointer is unchanged.
- R10: If a byte write and an increment hit the same pointer in one cycle, the written byte takes the write data and the other byte keeps its old value.
- R11: When modeWe is high on a clock edge, modeWrData[1:0] is loaded into the mode bits: bit 0 is redirect and bit 1 is index-disable.
- R12: With no instruction class active, dataIsB=0 and memAddr equals the effective pointer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrSelect | input | 1 | Selects the pointer used by the normal operand form |
| altPtr | input | 1 | Instruction uses the alternate (other) pointer |
| opExtRead | input | 1 | External-data read class |
| opExtWrite | input | 1 | External-data write class |
| opCodeRead | input | 1 | Indexed program-memory read class |
| accVal | input | 8 | Accumulator value used as index |
| modeWe | input | 1 | Load the mode bits |
| modeWrData | input | 2 | New mode bits (bit 0 redirect, bit 1 index-disable) |
| ptrWe | input | 1 | Pointer byte write strobe |
| ptrWrIdx | input | 1 | Pointer chosen for the byte write |
| ptrWrHigh | input | 1 | 1 writes the high byte, 0 the low byte |
| ptrWrData | input | 8 | Byte write data |
| incEn | input | 1 | Increment the effective pointer |
| memAddr | output | 16 | Effective memory address |
| dataIsB | output | 1 | 1 selects B, 0 selects the accumulator as data register |
| ptr0Val | output | 16 | Pointer 0 read-back |
| ptr1Val | output | 16 | Pointer 1 read-back |

## Verification
The assertions assume the decoder never raises more than one of the three class inputs in the same cycle. The data-register flag and the address rules are only defined for a single class. The random stimulus picks one class, or none, per vector, so it stays within that assumption. It also lets byte writes, increments and mode loads collide freely, because the unit defines an order for those collisions.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  parameter int BYTE_W  = 8;
  parameter int NUM_PTR = 2;
  localparam int PTR_W  = 2 * BYTE_W;
  localparam int SEL_W  = $clog2(NUM_PTR);

  typedef struct packed {
    logic [SEL_W-1:0]   effSel;
    logic               addIdx;
    logic               useB;
    logic [NUM_PTR-1:0] incHit;
    logic [NUM_PTR-1:0] hiWe;
    logic [NUM_PTR-1:0] loWe;
  } dpStrobe_t;
endpackage

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ptrSelect,
  input  logic             altPtr,
  input  logic             opExtRead,
  input  logic             opExtWrite,
  input  logic             opCodeRead,
  input  logic             modeWe,
  input  logic [1:0]       modeWrData,
  input  logic             ptrWe,
  input  logic [SEL_W-1:0] ptrWrIdx,
  input  logic             ptrWrHigh,
  input  logic             incEn,
  output dpStrobe_t        strb
);
  localparam int REDIR_BIT = 0;
  localparam int NOIDX_BIT = 1;

  logic [1:0]       modeReg;
  logic [SEL_W-1:0] effSel;
  logic             anyClass;

  always_ff @(posedge clk) begin
    if (!rstN)       modeReg <= '0;
    else if (modeWe) modeReg <= modeWrData;
  end

  assign effSel   = SEL_W'(ptrSelect ^ altPtr);
  assign anyClass = opExtRead | opExtWrite | opCodeRead;

  always_comb begin
    strb.effSel = effSel;
    strb.addIdx = opCodeRead & ~modeReg[NOIDX_BIT];
    strb.useB   = anyClass & modeReg[REDIR_BIT] & (effSel == SEL_W'(1));
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptrStrb
    logic wrHit;
    assign wrHit         = ptrWe & (ptrWrIdx == SEL_W'(i));
    assign strb.hiWe[i]  = wrHit & ptrWrHigh;
    assign strb.loWe[i]  = wrHit & ~ptrWrHigh;
    assign strb.incHit[i] = incEn & (effSel == SEL_W'(i));
  end

  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opExtRead, opExtWrite, opCodeRead})); // R12
  AST_B_NEEDS_PTR1: assert property (@(posedge clk) disable iff (!rstN)
    strb.useB |-> (ptrSelect ^ altPtr)); // R6
  AST_B_NEEDS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    strb.useB |-> (opExtRead | opExtWrite | opCodeRead)); // R12
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> modeReg == $past(modeWrData)); // R11
  AST_INC_ONE_PTR: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb.incHit) == (incEn ? 1 : 0)); // R9
endmodule

// File: rtl/dptr_datapath.sv
module dptr_datapath
  import dptr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strb,
  input  logic [BYTE_W-1:0]             wrData,
  input  logic [BYTE_W-1:0]             accVal,
  output logic [PTR_W-1:0]              memAddr,
  output logic [NUM_PTR-1:0][PTR_W-1:0] ptrVal
);
  logic [PTR_W-1:0] selVal;
  logic [PTR_W-1:0] idxExt;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic [BYTE_W-1:0] hiByte, loByte;
    logic [PTR_W-1:0]  incVal;

    assign incVal = {hiByte, loByte} + PTR_W'(1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        hiByte <= '0;
        loByte <= '0;
      end else if (strb.hiWe[i] || strb.loWe[i]) begin
        if (strb.hiWe[i]) hiByte <= wrData;
        if (strb.loWe[i]) loByte <= wrData;
      end else if (strb.incHit[i]) begin
        {hiByte, loByte} <= incVal;
      end
    end

    assign ptrVal[i] = {hiByte, loByte};

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (strb.incHit[i] && !strb.hiWe[i] && !strb.loWe[i])
      |=> ptrVal[i] == $past(ptrVal[i]) + PTR_W'(1)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.incHit[i] && !strb.hiWe[i] && !strb.loWe[i]) |=> $stable(ptrVal[i])); // R2
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
      strb.loWe[i] |=> (ptrVal[i][PTR_W-1:BYTE_W] == $past(ptrVal[i][PTR_W-1:BYTE_W])
                        && ptrVal[i][BYTE_W-1:0] == $past(wrData))); // R10
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
      strb.hiWe[i] |=> (ptrVal[i][BYTE_W-1:0] == $past(ptrVal[i][BYTE_W-1:0])
                        && ptrVal[i][PTR_W-1:BYTE_W] == $past(wrData))); // R10
  end

  assign selVal  = ptrVal[strb.effSel];
  assign idxExt  = strb.addIdx ? PTR_W'(accVal) : '0;
  assign memAddr = selVal + idxExt;
endmodule

// File: rtl/dptr_addr_unit.sv
module dptr_addr_unit
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrSelect,
  input  logic              altPtr,
  input  logic              opExtRead,
  input  logic              opExtWrite,
  input  logic              opCodeRead,
  input  logic [BYTE_W-1:0] accVal,
  input  logic              modeWe,
  input  logic [1:0]        modeWrData,
  input  logic              ptrWe,
  input  logic              ptrWrIdx,
  input  logic              ptrWrHigh,
  input  logic [BYTE_W-1:0] ptrWrData,
  input  logic              incEn,
  output logic [PTR_W-1:0]  memAddr,
  output logic              dataIsB,
  output logic [PTR_W-1:0]  ptr0Val,
  output logic [PTR_W-1:0]  ptr1Val
);
  dpStrobe_t                     strb;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrVal;

  dptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ptrSelect(ptrSelect), .altPtr(altPtr),
    .opExtRead(opExtRead), .opExtWrite(opExtWrite), .opCodeRead(opCodeRead),
    .modeWe(modeWe), .modeWrData(modeWrData),
    .ptrWe(ptrWe), .ptrWrIdx(SEL_W'(ptrWrIdx)), .ptrWrHigh(ptrWrHigh),
    .incEn(incEn), .strb(strb)
  );

  dptr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrData(ptrWrData), .accVal(accVal),
    .memAddr(memAddr), .ptrVal(ptrVal)
  );

  assign dataIsB = strb.useB;
  assign ptr0Val = ptrVal[0];
  assign ptr1Val = ptrVal[1];

  AST_EXT_NO_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (opExtRead || opExtWrite) |-> memAddr == ((ptrSelect ^ altPtr) ? ptr1Val : ptr0Val)); // R4
  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    !(opExtRead || opExtWrite || opCodeRead)
    |-> (memAddr == ((ptrSelect ^ altPtr) ? ptr1Val : ptr0Val) && !dataIsB)); // R12
  AST_PTR0_USES_ACC: assert property (@(posedge clk) disable iff (!rstN)
    !(ptrSelect ^ altPtr) |-> !dataIsB); // R6
endmodule

// File: tb/dptr_addr_unit_tb.sv
module dptr_addr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ptrSelect = 0, altPtr = 0;
  logic        opExtRead = 0, opExtWrite = 0, opCodeRead = 0;
  logic [7:0]  accVal = 0;
  logic        modeWe = 0;
  logic [1:0]  modeWrData = 0;
  logic        ptrWe = 0, ptrWrIdx = 0, ptrWrHigh = 0;
  logic [7:0]  ptrWrData = 0;
  logic        incEn = 0;
  logic [15:0] memAddr, ptr0Val, ptr1Val;
  logic        dataIsB;

  int checks = 0;
  int fails  = 0;
  int mPtr[2];
  int mMode;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dptr_addr_unit u_dut (
    .clk(clk), .rstN(rstN), .ptrSelect(ptrSelect), .altPtr(altPtr),
    .opExtRead(opExtRead), .opExtWrite(opExtWrite), .opCodeRead(opCodeRead),
    .accVal(accVal), .modeWe(modeWe), .modeWrData(modeWrData),
    .ptrWe(ptrWe), .ptrWrIdx(ptrWrIdx), .ptrWrHigh(ptrWrHigh),
    .ptrWrData(ptrWrData), .incEn(incEn),
    .memAddr(memAddr), .dataIsB(dataIsB), .ptr0Val(ptr0Val), .ptr1Val(ptr1Val)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare combinational outputs against the model, then advance one clock
  task automatic step();
    int eff, expAddr, expB;
    string aTag, bTag;
    #(CLK_PERIOD/4);
    eff = ptrSelect ^ altPtr;
    if (opCodeRead && (mMode & 2) == 0) expAddr = (mPtr[eff] + accVal) & 16'hFFFF;
    else                                expAddr = mPtr[eff];
    expB = ((mMode & 1) != 0 && eff == 1 && (opExtRead || opExtWrite || opCodeRead)) ? 1 : 0;
    if (opCodeRead)                    aTag = ((mMode & 2) != 0) ? "R8 index-disabled code addr" : "R8 indexed code addr (R3 pointer choice)";
    else if (opExtRead || opExtWrite)  aTag = "R4 external addr (R3 pointer choice)";
    else                               aTag = "R12 idle addr";
    if (eff == 0)        bTag = "R6 pointer 0 data reg";
    else if (opCodeRead) bTag = "R7 code read data reg";
    else if (opExtRead || opExtWrite) bTag = "R5 external data reg";
    else                 bTag = "R12 idle data reg";
    chk(aTag, memAddr, expAddr);
    chk(bTag, dataIsB, expB);
    chk("R2 pointer 0 readback", ptr0Val, mPtr[0]);
    chk("R2 pointer 1 readback", ptr1Val, mPtr[1]);
    @(posedge clk);
    // model update
    if (modeWe) mMode = modeWrData;
    for (int i = 0; i < 2; i++) begin
      if (ptrWe && ptrWrIdx == i) begin
        if (ptrWrHigh) mPtr[i] = (mPtr[i] & 16'h00FF) | (ptrWrData << 8);
        else           mPtr[i] = (mPtr[i] & 16'hFF00) | ptrWrData;
      end else if (incEn && eff == i) begin
        mPtr[i] = (mPtr[i] + 1) & 16'hFFFF;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    {opExtRead, opExtWrite, opCodeRead, modeWe, ptrWe, incEn} = '0;
  endtask

  task automatic wrPtr(input bit idx, input int val);
    idle(); ptrWe = 1; ptrWrIdx = idx;
    ptrWrHigh = 1; ptrWrData = val[15:8]; step();
    ptrWrHigh = 0; ptrWrData = val[7:0];  step();
    idle();
  endtask

  task automatic setMode(input int m);
    idle(); modeWe = 1; modeWrData = m[1:0]; step(); idle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run hung");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    mPtr[0] = 0; mPtr[1] = 0; mMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state, code read indexes with acc and uses accumulator
    opCodeRead = 1; accVal = 8'h5A;
    chk("R1 reset ptr0", ptr0Val, 0);
    chk("R1 reset ptr1", ptr1Val, 0);
    #1;
    chk("R1 reset code addr", memAddr, 16'h005A);
    chk("R1 reset data reg", dataIsB, 0);
    step(); idle();

    // R2 byte writes, R9 wrap
    wrPtr(0, 16'h1234);
    wrPtr(1, 16'hFFFF);
    ptrSelect = 1; altPtr = 0; incEn = 1; step(); idle();
    chk("R9 wrap to zero", ptr1Val, 0);
    chk("R9 other pointer kept", ptr0Val, 16'h1234);

    // R3 alternate form with select=1 uses pointer 0
    wrPtr(1, 16'hABCD);
    ptrSelect = 1; altPtr = 1; opExtRead = 1; #1;
    chk("R3 alt form select=1 addr", memAddr, 16'h1234);
    step(); idle();

    // R11 redirect, R5 ext via ptr1 -> B
    setMode(1);
    ptrSelect = 1; altPtr = 0; opExtWrite = 1; #1;
    chk("R5 redirect write via ptr1", dataIsB, 1);
    chk("R4 redirect leaves ext addr", memAddr, 16'hABCD);
    step(); idle();
    // R7 code read through ptr1 loads B, index is still acc
    opCodeRead = 1; accVal = 8'h40; #1;
    chk("R7 code read via ptr1 data reg", dataIsB, 1);
    chk("R7 index still accumulator", memAddr, 16'hAC0D);
    step(); idle();
    // R6 ptr0 keeps accumulator
    ptrSelect = 0; opExtRead = 1; #1;
    chk("R6 ptr0 under redirect", dataIsB, 0);
    step(); idle();

    // R8 index disable with wrap check on indexed sum
    setMode(2);
    ptrSelect = 1; opCodeRead = 1; accVal = 8'hFF; #1;
    chk("R8 index disabled addr", memAddr, 16'hABCD);
    chk("R8 no redirect without bit0", dataIsB, 0);
    step(); idle();
    setMode(0);
    wrPtr(0, 16'hFFF0);
    ptrSelect = 0; opCodeRead = 1; accVal = 8'h20; #1;
    chk("R8 indexed sum wraps", memAddr, 16'h0010);
    step(); idle();

    // R10 write and increment collide on same pointer
    ptrSelect = 0; incEn = 1; ptrWe = 1; ptrWrIdx = 0; ptrWrHigh = 0; ptrWrData = 8'h77;
    step(); idle();
    chk("R10 write wins over increment", ptr0Val, 16'hFF77);

    // R12 idle
    setMode(3);
    ptrSelect = 1; #1;
    chk("R12 idle data reg", dataIsB, 0);
    step();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int cls;
      idle();
      ptrSelect  = $urandom_range(0, 1);
      altPtr     = $urandom_range(0, 1);
      accVal     = $urandom_range(0, 255);
      cls        = $urandom_range(0, 3);
      opExtRead  = (cls == 1);
      opExtWrite = (cls == 2);
      opCodeRead = (cls == 3);
      modeWe     = ($urandom_range(0, 7) == 0);
      modeWrData = $urandom_range(0, 3);
      ptrWe      = ($urandom_range(0, 3) == 0);
      ptrWrIdx   = $urandom_range(0, 1);
      ptrWrHigh  = $urandom_range(0, 1);
      ptrWrData  = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      incEn      = ($urandom_range(0, 2) == 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule